// File: doc/BRIEF.md
# Serial symbol aligner with jog

The aligner sits behind a serial receiver's deserializer and turns a raw 10-bit word stream into words that start on symbol boundaries. Each incoming word can first be bit-inverted to undo swapped differential wiring. The block then keeps the newest word and the nine low bits of the word before it, and picks one 10-bit window from that 19-bit span. The chosen window is set by a bit offset from 0 to 9.

A 2-bit mode input decides how the offset moves:
- `00` (hold) freezes the offset.
- `01` (comma) searches every candidate window for a comma pattern and moves the offset to the comma it finds.
- `10` (jog) slips the boundary by one bit each time the mode is entered.
- `11` is reserved and holds, like `00`.

An enable input stalls the whole block. While it is low, the output valid flag is low.

Buffer convention: the search span is `{older[8:0], newer[9:0]}`, where `older` is the word received on the enabled edge before `newer`. Bit positions are numbered from 0 at `newer[0]`. The window at offset k is span bits `[k+9:k]`, and bit 9 of a window is the first bit of the symbol.

Top module: `sym_aligner`

## Requirements
- R1: A word taken on an enabled edge appears on `sym_o` after the second enabled edge. At offset k, `sym_o` equals `{older[k-1:0], newer[9:k]}` for the pair held after the first edge. At offset 0, `sym_o` equals that word.
- R2: On an enabled edge with mode `00`, `offset_o` and `aligned_o` keep their values.
- R3: On an enabled edge with mode `01`, each window is tested for a comma. A window is a comma when its bits [9:3] are `0011111` or `1100000`. If the window at the current offset is a comma, `aligned_o` becomes 1. Otherwise, if any other window is a comma, `offset_o` takes the lowest such k and `aligned_o` becomes 0. If no window is a comma, both hold.
- R4: On an enabled edge with mode `10`, the offset advances by one (9 wraps to 0) and `aligned_o` clears, but only when mode bit 1 was 0 on the previous enabled edge. Staying in `10` does nothing further.
- R5: Mode `11` holds the offset and `aligned_o`. This is true even when it is entered from a mode with bit 1 low.
- R6: With `invert_i` high, a word is complemented before it enters the buffer. The comma search and the output both see the inverted bits.
- R7: An edge with `en_i` low drives `sym_valid_o` to 0. That edge leaves the offset, `aligned_o`, the buffer and the stored mode bit unchanged.
- R8: While `rst_ni` is low, `offset_o` = 0, `aligned_o` = 0, `sym_valid_o` = 0 and `sym_o` = 0, and the buffer is cleared. This takes effect asynchronously.
- R9: `offset_o` never exceeds 9. Any edge that changes `offset_o` leaves `aligned_o` at 0.
- R10: `sym_valid_o` is 1 after an enabled edge when at least one earlier enabled edge has occurred since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable; low stalls the block |
| invert_i | input | 1 | Complement incoming bits |
| mode_i | input | 2 | 00 hold, 01 comma, 10 jog, 11 hold |
| data_i | input | 10 | Deserialized word |
| sym_o | output | 10 | Aligned symbol |
| sym_valid_o | output | 1 | `sym_o` carries a symbol |
| aligned_o | output | 1 | Comma seen at current offset |
| offset_o | output | 4 | Current bit offset, 0 to 9 |

## Verification
An offset or aligned-flag decision is visible one edge after the edge that captured the words it examines, so it uses the pair held from the edge before the mode is applied. The aligned symbol is visible two edges after its word was driven. The bench drives inputs on the falling edge and reads results at the next falling edge, one rising edge later. Each expected vector and each directed check is written against that one-edge step, and the latency test waits exactly two steps between the second word and the read.

// File: rtl/sym_align_pkg.sv
package sym_align_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_COMMA = 2'b01,
    MODE_JOG   = 2'b10,
    MODE_RSVD  = 2'b11
  } align_mode_e;

  localparam int unsigned COMMA_W = 7;
  localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111;
endpackage

// File: rtl/sym_align_buf.sv
module sym_align_buf #(
  parameter int unsigned SYM_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               invert_i,
  input  logic [SYM_W-1:0]   data_i,
  output logic [2*SYM_W-2:0] span_o,
  output logic               fill_o
);
  logic [SYM_W-1:0] newer_q;
  logic [SYM_W-2:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      newer_q <= '0;
      older_q <= '0;
      fill_o  <= 1'b0;
    end else if (en_i) begin
      newer_q <= data_i ^ {SYM_W{invert_i}};
      older_q <= newer_q[SYM_W-2:0];
      fill_o  <= 1'b1;
    end
  end

  assign span_o = {older_q, newer_q};
endmodule

// File: rtl/sym_align_ctrl.sv
module sym_align_ctrl
  import sym_align_pkg::*;
#(
  parameter int unsigned SYM_W  = 10,
  parameter int unsigned OFF_W  = $clog2(SYM_W),
  parameter int unsigned SRCH_W = SYM_W + COMMA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [SRCH_W-1:0] srch_i,
  output logic [OFF_W-1:0]  offset_o,
  output logic              aligned_o
);
  logic [SYM_W-1:0] hit;
  logic             cur_hit;
  logic [OFF_W-1:0] first_k;
  logic             mode_hi_q;

  // srch_i[k +: COMMA_W] is the upper COMMA_W bits of window k
  for (genvar k = 0; k < SYM_W; k++) begin : g_hit
    assign hit[k] = (srch_i[k +: COMMA_W] == COMMA_PAT) ||
                    (srch_i[k +: COMMA_W] == ~COMMA_PAT);
  end

  always_comb begin
    cur_hit = 1'b0;
    first_k = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      if (hit[k]) first_k = OFF_W'(k);
      if (OFF_W'(k) == offset_o) cur_hit = hit[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o  <= '0;
      aligned_o <= 1'b0;
      mode_hi_q <= 1'b0;
    end else if (en_i) begin
      mode_hi_q <= mode_i[1];
      unique case (align_mode_e'(mode_i))
        MODE_COMMA: begin
          if (cur_hit) begin
            aligned_o <= 1'b1;
          end else if (|hit) begin
            offset_o  <= first_k;
            aligned_o <= 1'b0;
          end
        end
        MODE_JOG: begin
          if (!mode_hi_q) begin
            offset_o  <= (offset_o == OFF_W'(SYM_W - 1)) ? '0 : offset_o + 1'b1;
            aligned_o <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sym_align_out.sv
module sym_align_out #(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned OFF_W = $clog2(SYM_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               fill_i,
  input  logic [2*SYM_W-2:0] span_i,
  input  logic [OFF_W-1:0]   offset_i,
  output logic [SYM_W-1:0]   sym_o,
  output logic               sym_valid_o
);
  logic [SYM_W-1:0] win;

  always_comb begin
    win = span_i[SYM_W-1:0];
    for (int k = 0; k < SYM_W; k++) begin
      if (OFF_W'(k) == offset_i) win = span_i[k +: SYM_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o       <= '0;
      sym_valid_o <= 1'b0;
    end else if (en_i) begin
      sym_o       <= win;
      sym_valid_o <= fill_i;
    end else begin
      sym_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sym_aligner.sv
module sym_aligner
  import sym_align_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned OFF_W = $clog2(SYM_W),
  localparam int unsigned SPAN_W = 2 * SYM_W - 1,
  localparam int unsigned SRCH_W = SYM_W + COMMA_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             invert_i,
  input  logic [1:0]       mode_i,
  input  logic [SYM_W-1:0] data_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             sym_valid_o,
  output logic             aligned_o,
  output logic [OFF_W-1:0] offset_o
);
  logic [SPAN_W-1:0] span;
  logic              fill;

  sym_align_buf #(.SYM_W(SYM_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .invert_i (invert_i),
    .data_i   (data_i),
    .span_o   (span),
    .fill_o   (fill)
  );

  sym_align_ctrl #(.SYM_W(SYM_W), .OFF_W(OFF_W), .SRCH_W(SRCH_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode_i),
    .srch_i    (span[SPAN_W-1:SYM_W-COMMA_W]),
    .offset_o  (offset_o),
    .aligned_o (aligned_o)
  );

  sym_align_out #(.SYM_W(SYM_W), .OFF_W(OFF_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .fill_i      (fill),
    .span_i      (span),
    .offset_i    (offset_o),
    .sym_o       (sym_o),
    .sym_valid_o (sym_valid_o)
  );
endmodule

// File: rtl/sym_aligner_chk.sv
module sym_aligner_chk #(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned OFF_W = $clog2(SYM_W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic             sym_valid_o,
  input logic             aligned_o,
  input logic [OFF_W-1:0] offset_o
);
  // R9
  offset_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_o <= OFF_W'(SYM_W - 1));

  // R9
  realign_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offset_o != $past(offset_o)) |-> !aligned_o);

  // R7
  stall_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sym_valid_o);

  // R7
  stall_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(offset_o) && $stable(aligned_o)));

  // R2 R5
  hold_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=>
      ($stable(offset_o) && $stable(aligned_o)));

  // R4
  jog_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b10) |=>
      (offset_o == $past(offset_o) ||
       offset_o == (($past(offset_o) == OFF_W'(SYM_W - 1)) ? '0 : $past(offset_o) + 1'b1)));
endmodule

bind sym_aligner sym_aligner_chk #(.SYM_W(SYM_W), .OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .mode_i      (mode_i),
  .sym_valid_o (sym_valid_o),
  .aligned_o   (aligned_o),
  .offset_o    (offset_o)
);

// File: tb/sym_aligner_test.sv
`timescale 1ns/1ps
module sym_aligner_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       invert_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [9:0] data_i = '0;
  logic [9:0] sym_o;
  logic       sym_valid_o;
  logic       aligned_o;
  logic [3:0] offset_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sym_aligner uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .invert_i(invert_i),
    .mode_i(mode_i), .data_i(data_i), .sym_o(sym_o), .sym_valid_o(sym_valid_o),
    .aligned_o(aligned_o), .offset_o(offset_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic en, logic [1:0] md, logic inv, logic [9:0] d);
    en_i = en; mode_i = md; invert_i = inv; data_i = d;
    @(negedge clk_i);
  endtask

  // {mode, invert, data, exp offset, exp aligned, req}
  localparam int NV = 25;
  localparam logic [21:0] VEC [NV] = '{
    {2'b00, 1'b0, 10'h000, 4'd0, 1'b0, 4'd2},  // R2
    {2'b01, 1'b0, 10'h0F8, 4'd0, 1'b0, 4'd3},  // R3 no comma yet
    {2'b01, 1'b0, 10'h000, 4'd0, 1'b1, 4'd3},  // R3 comma at offset 0
    {2'b00, 1'b0, 10'h000, 4'd0, 1'b1, 4'd2},
    {2'b01, 1'b0, 10'h001, 4'd0, 1'b1, 4'd3},
    {2'b01, 1'b0, 10'h3C0, 4'd0, 1'b1, 4'd3},
    {2'b01, 1'b0, 10'h000, 4'd3, 1'b0, 4'd3},  // R3 moves to 3
    {2'b00, 1'b0, 10'h000, 4'd3, 1'b0, 4'd2},
    {2'b00, 1'b0, 10'h001, 4'd3, 1'b0, 4'd2},
    {2'b00, 1'b0, 10'h3C0, 4'd3, 1'b0, 4'd2},
    {2'b01, 1'b0, 10'h000, 4'd3, 1'b1, 4'd3},  // R3 comma at offset
    {2'b00, 1'b0, 10'h000, 4'd3, 1'b1, 4'd2},
    {2'b10, 1'b0, 10'h000, 4'd4, 1'b0, 4'd4},  // R4 jog
    {2'b10, 1'b0, 10'h000, 4'd4, 1'b0, 4'd4},  // R4 no repeat
    {2'b00, 1'b0, 10'h000, 4'd4, 1'b0, 4'd2},
    {2'b10, 1'b0, 10'h000, 4'd5, 1'b0, 4'd4},
    {2'b11, 1'b0, 10'h000, 4'd5, 1'b0, 4'd5},  // R5
    {2'b10, 1'b0, 10'h000, 4'd5, 1'b0, 4'd4},
    {2'b01, 1'b0, 10'h000, 4'd5, 1'b0, 4'd3},
    {2'b11, 1'b0, 10'h000, 4'd5, 1'b0, 4'd5},  // R5 entered from bit1 low
    {2'b00, 1'b1, 10'h3FF, 4'd5, 1'b0, 4'd6},  // R6
    {2'b00, 1'b1, 10'h3FE, 4'd5, 1'b0, 4'd6},
    {2'b00, 1'b1, 10'h03F, 4'd5, 1'b0, 4'd6},
    {2'b01, 1'b0, 10'h000, 4'd3, 1'b0, 4'd6},  // R6 inverted comma found
    {2'b00, 1'b0, 10'h000, 4'd3, 1'b0, 4'd2}
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R8 reset state
    chk("R8", {12'd0, offset_o}, 16'd0);
    chk("R8", {15'd0, aligned_o}, 16'd0);
    chk("R8", {15'd0, sym_valid_o}, 16'd0);
    chk("R8", {6'd0, sym_o}, 16'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      string tag;
      v = VEC[i];
      step(1'b1, v[21:20], v[19], v[18:9]);
      tag = $sformatf("R%0d vec %0d", v[3:0], i);
      chk(tag, {12'd0, offset_o}, {12'd0, v[8:5]});
      chk(tag, {15'd0, aligned_o}, {15'd0, v[4]});
      if (i == 0) chk("R10 first edge", {15'd0, sym_valid_o}, 16'd0);
      if (i == 1) chk("R10 second edge", {15'd0, sym_valid_o}, 16'd1);
      if (i == 2) chk("R1 offset 0", {6'd0, sym_o}, 16'h0F8);
    end

    // R1 window at offset 3, two-edge latency
    step(1'b1, 2'b00, 1'b0, 10'h2A5);
    step(1'b1, 2'b00, 1'b0, 10'h15A);
    step(1'b1, 2'b00, 1'b0, 10'h000);
    chk("R1 offset 3", {6'd0, sym_o}, 16'h2AB);
    chk("R10", {15'd0, sym_valid_o}, 16'd1);

    // R4 wrap 9 -> 0
    for (int j = 0; j < 7; j++) begin
      step(1'b1, 2'b00, 1'b0, 10'h000);
      step(1'b1, 2'b10, 1'b0, 10'h000);
      chk("R4 jog", {12'd0, offset_o}, (j == 6) ? 16'd0 : 16'(4 + j));
    end

    // R7 stall: stored mode bit is frozen while disabled
    step(1'b0, 2'b00, 1'b0, 10'h155);
    chk("R7 valid low", {15'd0, sym_valid_o}, 16'd0);
    chk("R7 hold", {12'd0, offset_o}, 16'd0);
    step(1'b1, 2'b10, 1'b0, 10'h000);
    chk("R7 mode bit frozen", {12'd0, offset_o}, 16'd0);
    step(1'b1, 2'b00, 1'b0, 10'h000);
    step(1'b0, 2'b10, 1'b0, 10'h000);
    chk("R7 no jog when off", {12'd0, offset_o}, 16'd0);
    chk("R7 valid low", {15'd0, sym_valid_o}, 16'd0);
    step(1'b1, 2'b10, 1'b0, 10'h000);
    chk("R4 jog after stall", {12'd0, offset_o}, 16'd1);
    chk("R10 valid back", {15'd0, sym_valid_o}, 16'd1);

    // R8 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R8 async", {12'd0, offset_o}, 16'd0);
    chk("R8 async", {15'd0, sym_valid_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 2'b00, 1'b0, 10'h000);
    chk("R8 after release", {15'd0, sym_valid_o}, 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule